// File: doc/BRIEF.md
# Boot Sector Write Protection

This block sits beside a flash command controller. It maps word addresses onto four erase sectors: a boot sector, two parameter sectors and a main sector. A parameter selects whether the boot sector occupies the lowest or the highest addresses. When the controller passes it a decoded program, sector-erase or chip-erase request, the block replies one cycle later. The reply says whether the operation may run and gives the set of sectors it is allowed to change.

The block also keeps a sticky lock bit for the boot sector. The controller arms it after recognising the arming command sequence. A normal reset does not clear the bit; only the power-on reset does, which stands in for non-volatile storage.

While the bit is set, a program or sector erase aimed at the boot sector is refused and the controller goes straight back to read mode. A chip erase still runs, but the boot sector is left out of its mask. A high-voltage override flag lifts the protection, but only if it is held until the operation ends. If the flag drops early, the block raises a fault pulse. In identification mode, a read of the word two places above the boot sector's base returns the lock bit.

Top module: `sector_guard`

## Requirements
- R1: With `TOP_BOOT=0`, `resp_sector` classifies the request address as follows: 0 (boot) for 0x00000–0x01FFF, 1 for 0x02000–0x02FFF, 2 for 0x03000–0x03FFF, and 3 (main) for 0x04000 and above.
- R2: With `TOP_BOOT=1`, `resp_sector` classifies the request address as follows: 0 for 0x7E000–0x7FFFF, 1 for 0x7D000–0x7DFFF, 2 for 0x7C000–0x7CFFF, and 3 for 0x7BFFF and below.
- R3: `por_n` low clears the lock bit. `rst_n` low leaves the lock bit unchanged.
- R4: A cycle with `arm_lock` high while `rst_n` is high sets the lock bit, and the bit then stays set.
- R5: `req_kind` uses 1 for program, 2 for sector erase and 3 for chip erase; 0 means no request. A program or sector erase that is not refused gives `resp_grant`=1 and a `resp_mask` with only bit `resp_sector` set. `resp_prog` is 1 only for a granted program.
- R6: When the lock is set and `hv_override` is low, a program or sector erase to sector 0 gives `resp_grant`=0, `resp_mask`=0 and `resp_prog`=0.
- R7: A chip erase is always granted. Its mask is 4'b1111, or 4'b1110 when the lock is set and `hv_override` is low.
- R8: When `hv_override` is high in the request cycle, the lock has no effect on that request.
- R9: If a request granted through the override touched sector 0, and `hv_override` drops before `op_done`, `ov_fault` pulses high for one cycle. If the flag is held until `op_done`, no fault is raised.
- R10: With `id_mode` high, a read address equal to the boot base plus 2 gives `id_valid`=1 and `id_data` bit 0 = lock bit one cycle later. Any other read gives `id_valid`=0 and `id_data`=0.
- R11: `resp_valid` is high exactly in the cycle after a cycle that had `req_valid` high with a nonzero `req_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (leaves the lock bit unchanged) |
| por_n | input | 1 | Synchronous active-low power-on reset, clears the lock bit |
| arm_lock | input | 1 | Pulse: arming sequence recognised |
| hv_override | input | 1 | High-voltage override flag |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Request kind: 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | ADDR_W | Word address of the request |
| op_done | input | 1 | Pulse from controller: running operation finished |
| id_mode | input | 1 | Identification read mode |
| rd_addr | input | ADDR_W | Read address |
| resp_valid | output | 1 | Decision valid |
| resp_grant | output | 1 | Operation may run |
| resp_prog | output | 1 | Granted program |
| resp_sector | output | 2 | Sector of request address |
| resp_mask | output | 4 | Sectors that may be changed |
| ov_fault | output | 1 | Override dropped during protected operation |
| id_valid | output | 1 | Lock status word returned |
| id_data | output | DATA_W | Status word, bit 0 is the lock bit |

## Verification
The hardest case to reach is an operation granted through the override whose flag then drops before completion. This needs the lock armed, a boot-sector request made with the override held, and the flag released in the window before `op_done`. The directed sequence builds exactly this, then repeats it with the flag kept through `op_done` to show that no fault appears. Random requests are biased toward the low and high sector boundaries, and they run both before and after arming so that both mask rules are exercised. A second instance checks the top-boot classification on the same stimulus.

// File: rtl/sector_pkg.sv
// Shared types for the boot sector protection block.
package sector_pkg;
    // Request kinds as issued by the command controller.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;

    localparam int unsigned NUM_SECTORS = 4;
    localparam int unsigned SECT_W      = 2;
    localparam logic [SECT_W-1:0] SECT_BOOT = 2'd0;
endpackage

// File: rtl/sector_classify.sv
// Combinational address-to-sector map.
// Assumes the boot sector and the two parameter sectors are adjacent at one end of the
// address space. The top-boot variant inverts the address so that one comparison chain
// serves both layouts.
module sector_classify #(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter bit          TOP_BOOT    = 1'b0
) (
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [sector_pkg::SECT_W-1:0]  sector_o
);
    localparam logic [ADDR_W-1:0] LIM_BOOT = ADDR_W'(BOOT_WORDS);
    localparam logic [ADDR_W-1:0] LIM_P1   = ADDR_W'(BOOT_WORDS + PARAM_WORDS);
    localparam logic [ADDR_W-1:0] LIM_P2   = ADDR_W'(BOOT_WORDS + 2 * PARAM_WORDS);

    logic [ADDR_W-1:0] norm;

    // Fold the top-boot layout onto the bottom-boot one.
    generate
        if (TOP_BOOT) begin : g_top
            assign norm = ~addr_i;
        end else begin : g_bottom
            assign norm = addr_i;
        end
    endgenerate

    // Compare against the three sector limits, nearest the boot end first.
    always_comb begin
        if (norm < LIM_BOOT)      sector_o = 2'd0;
        else if (norm < LIM_P1)   sector_o = 2'd1;
        else if (norm < LIM_P2)   sector_o = 2'd2;
        else                      sector_o = 2'd3;
    end
endmodule

// File: rtl/lock_store.sv
// Sticky boot-sector lock bit.
// Clears only on the power-on reset, modelling non-volatile storage. It is armed by a
// one-cycle pulse from the command decoder, which is ignored while the normal reset is held.
module lock_store (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic arm_i,
    output logic lock_o
);
    // Set on arm, clear only on power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n)                lock_o <= 1'b0;
        else if (rst_n && arm_i)   lock_o <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        lock_o |=> lock_o); // R3
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && arm_i) |=> lock_o); // R4
endmodule

// File: rtl/write_gate.sv
// Decides each program or erase request against the lock and the override flag.
// It also watches that an override-granted boot operation keeps the flag until op_done.
// Assumes a single operation is in flight at a time and that op_done ends it.
module write_gate #(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter bit          TOP_BOOT    = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lock_i,
    input  logic                              hv_override_i,
    input  logic                              req_valid_i,
    input  logic [1:0]                        req_kind_i,
    input  logic [ADDR_W-1:0]                 req_addr_i,
    input  logic                              op_done_i,
    output logic                              resp_valid_o,
    output logic                              resp_grant_o,
    output logic                              resp_prog_o,
    output logic [sector_pkg::SECT_W-1:0]     resp_sector_o,
    output logic [sector_pkg::NUM_SECTORS-1:0] resp_mask_o,
    output logic                              ov_fault_o
);
    import sector_pkg::*;

    localparam logic [NUM_SECTORS-1:0] ALL_SECT = {NUM_SECTORS{1'b1}};
    localparam logic [NUM_SECTORS-1:0] NO_BOOT  = ALL_SECT & ~(NUM_SECTORS'(1) << SECT_BOOT);

    op_kind_e                 kind;
    logic [SECT_W-1:0]        sector;
    logic                     boot_prot;
    logic                     grant_d;
    logic [NUM_SECTORS-1:0]   mask_d;
    logic                     ov_hold;
    logic                     chip_q;

    assign kind = op_kind_e'(req_kind_i);

    sector_classify #(
        .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS),
        .PARAM_WORDS(PARAM_WORDS), .TOP_BOOT(TOP_BOOT)
    ) u_map (
        .addr_i   (req_addr_i),
        .sector_o (sector)
    );

    assign boot_prot = lock_i && !hv_override_i;

    // Grant and sector mask for the request in this cycle.
    always_comb begin
        grant_d = 1'b0;
        mask_d  = '0;
        unique case (kind)
            OP_PROG, OP_SECT: begin
                if (!(boot_prot && sector == SECT_BOOT)) begin
                    grant_d = 1'b1;
                    mask_d  = NUM_SECTORS'(1) << sector;
                end
            end
            OP_CHIP: begin
                grant_d = 1'b1;
                mask_d  = boot_prot ? NO_BOOT : ALL_SECT;
            end
            default: begin
                grant_d = 1'b0;
                mask_d  = '0;
            end
        endcase
    end

    // Register the decision one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o  <= 1'b0;
            resp_grant_o  <= 1'b0;
            resp_prog_o   <= 1'b0;
            resp_sector_o <= '0;
            resp_mask_o   <= '0;
            chip_q        <= 1'b0;
        end else begin
            resp_valid_o  <= req_valid_i && (kind != OP_NONE);
            resp_grant_o  <= req_valid_i && grant_d;
            resp_prog_o   <= req_valid_i && grant_d && (kind == OP_PROG);
            resp_sector_o <= sector;
            resp_mask_o   <= req_valid_i ? mask_d : '0;
            chip_q        <= req_valid_i && (kind == OP_CHIP);
        end
    end

    // Track an override-granted boot operation and flag an early release of the override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_hold    <= 1'b0;
            ov_fault_o <= 1'b0;
        end else begin
            ov_fault_o <= 1'b0;
            if (req_valid_i && grant_d && mask_d[SECT_BOOT] && lock_i) begin
                ov_hold <= 1'b1;
            end else if (ov_hold && op_done_i) begin
                ov_hold <= 1'b0;
            end else if (ov_hold && !hv_override_i) begin
                ov_hold    <= 1'b0;
                ov_fault_o <= 1'b1;
            end
        end
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i != 2'd0) |=> resp_valid_o); // R11
    AST_BLOCKED_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && !resp_grant_o) |-> (resp_mask_o == '0 && !resp_prog_o)); // R6
    AST_SINGLE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && !chip_q) |-> $onehot0(resp_mask_o)); // R5
    AST_CHIP_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && chip_q) |-> (resp_grant_o && resp_mask_o[NUM_SECTORS-1:1] == '1)); // R7
    AST_LOCKED_BOOT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_mask_o[SECT_BOOT]) |-> $past(!lock_i || hv_override_i)); // R8
    AST_FAULT_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault_o |-> $past(!hv_override_i)); // R9
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault_o |=> !ov_fault_o); // R9
endmodule

// File: rtl/id_status.sv
// Identification-mode read of the lock status word.
// The status word sits two words above the boot sector's base. Every other address
// returns zero with the valid flag low. Assumes one cycle of read latency suits the controller.
module id_status #(
    parameter int unsigned ADDR_W     = 19,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned BOOT_WORDS = 8192,
    parameter bit          TOP_BOOT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              id_valid_o,
    output logic [DATA_W-1:0] id_data_o
);
    localparam logic [ADDR_W-1:0] ID_ADDR =
        ADDR_W'(TOP_BOOT ? ((64'd1 << ADDR_W) - 64'(BOOT_WORDS) + 64'd2) : 64'd2);

    logic hit;
    assign hit = id_mode_i && (rd_addr_i == ID_ADDR);

    // Register the status word for the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid_o <= 1'b0;
            id_data_o  <= '0;
        end else begin
            id_valid_o <= hit;
            id_data_o  <= hit ? DATA_W'(lock_i) : '0;
        end
    end

    AST_ID_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid_o |-> $past(id_mode_i)); // R10
    AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid_o |-> (id_data_o == '0)); // R10
endmodule

// File: rtl/sector_guard.sv
// Top of the boot sector protection block.
// It joins the lock bit, the request gate and the identification status read.
// Assumes the command controller decodes the command sequences and runs the array timing.
module sector_guard #(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter bit          TOP_BOOT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              arm_lock,
    input  logic              hv_override,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              op_done,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              resp_prog,
    output logic [1:0]        resp_sector,
    output logic [3:0]        resp_mask,
    output logic              ov_fault,
    output logic              id_valid,
    output logic [DATA_W-1:0] id_data
);
    logic locked;

    lock_store u_lock (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .arm_i  (arm_lock),
        .lock_o (locked)
    );

    write_gate #(
        .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS),
        .PARAM_WORDS(PARAM_WORDS), .TOP_BOOT(TOP_BOOT)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_i        (locked),
        .hv_override_i (hv_override),
        .req_valid_i   (req_valid),
        .req_kind_i    (req_kind),
        .req_addr_i    (req_addr),
        .op_done_i     (op_done),
        .resp_valid_o  (resp_valid),
        .resp_grant_o  (resp_grant),
        .resp_prog_o   (resp_prog),
        .resp_sector_o (resp_sector),
        .resp_mask_o   (resp_mask),
        .ov_fault_o    (ov_fault)
    );

    id_status #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BOOT_WORDS(BOOT_WORDS), .TOP_BOOT(TOP_BOOT)
    ) u_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_i     (locked),
        .id_mode_i  (id_mode),
        .rd_addr_i  (rd_addr),
        .id_valid_o (id_valid),
        .id_data_o  (id_data)
    );
endmodule

// File: tb/sector_guard_test.sv
module sector_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0, arm_lock = 1'b0, hv_override = 1'b0;
    logic req_valid = 1'b0, op_done = 1'b0, id_mode = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0, rd_addr = '0;

    logic b_valid, b_grant, b_prog, b_fault, b_idv;
    logic [1:0] b_sect;
    logic [3:0] b_mask;
    logic [DW-1:0] b_idd;
    logic t_valid, t_grant, t_prog, t_fault, t_idv;
    logic [1:0] t_sect;
    logic [3:0] t_mask;
    logic [DW-1:0] t_idd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_lock = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_guard #(.TOP_BOOT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .arm_lock(arm_lock),
        .hv_override(hv_override), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .op_done(op_done), .id_mode(id_mode), .rd_addr(rd_addr),
        .resp_valid(b_valid), .resp_grant(b_grant), .resp_prog(b_prog),
        .resp_sector(b_sect), .resp_mask(b_mask), .ov_fault(b_fault),
        .id_valid(b_idv), .id_data(b_idd));

    sector_guard #(.TOP_BOOT(1'b1)) uut_top (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .arm_lock(arm_lock),
        .hv_override(hv_override), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .op_done(op_done), .id_mode(id_mode), .rd_addr(rd_addr),
        .resp_valid(t_valid), .resp_grant(t_grant), .resp_prog(t_prog),
        .resp_sector(t_sect), .resp_mask(t_mask), .ov_fault(t_fault),
        .id_valid(t_idv), .id_data(t_idd));

    function automatic logic [1:0] sect_bottom(logic [AW-1:0] a);
        if (a < 19'h02000) return 2'd0;
        if (a < 19'h03000) return 2'd1;
        if (a < 19'h04000) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [1:0] sect_top(logic [AW-1:0] a);
        if (a >= 19'h7E000) return 2'd0;
        if (a >= 19'h7D000) return 2'd1;
        if (a >= 19'h7C000) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic exp_grant(logic [1:0] k, logic [1:0] s, bit lk, logic ov);
        if (k == 2'd3) return 1'b1;
        return !(lk && !ov && s == 2'd0);
    endfunction

    function automatic logic [3:0] exp_mask(logic [1:0] k, logic [1:0] s, bit lk, logic ov);
        if (k == 2'd3) return (lk && !ov) ? 4'b1110 : 4'b1111;
        if (!exp_grant(k, s, lk, ov)) return 4'b0000;
        return 4'b0001 << s;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive one request, then check both instances one cycle later.
    task automatic do_req(logic [1:0] k, logic [AW-1:0] a, logic ov);
        logic [1:0] sb;
        logic [1:0] st;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; hv_override = ov;
        @(posedge clk);
        @(negedge clk);
        sb = sect_bottom(a);
        st = sect_top(a);
        chk("R11 resp_valid", 32'(b_valid), 32'(1));
        chk("R1 bottom sector", 32'(b_sect), 32'(sb));
        chk("R2 top sector", 32'(t_sect), 32'(st));
        chk("R5 R6 R8 grant", 32'(b_grant), 32'(exp_grant(k, sb, model_lock, ov)));
        chk("R5 R6 R7 mask", 32'(b_mask), 32'(exp_mask(k, sb, model_lock, ov)));
        chk("R5 prog flag", 32'(b_prog), 32'((k == 2'd1) && exp_grant(k, sb, model_lock, ov)));
        chk("R7 R8 top mask", 32'(t_mask), 32'(exp_mask(k, st, model_lock, ov)));
        req_valid = 1'b0; req_kind = 2'd0;
    endtask

    // Identification read on both instances.
    task automatic do_id(logic [AW-1:0] a);
        bit hb;
        bit ht;
        @(negedge clk);
        id_mode = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        hb = (a == 19'h00002);
        ht = (a == 19'h7E002);
        chk("R10 bottom id_valid", 32'(b_idv), 32'(hb));
        chk("R10 bottom id_data", 32'(b_idd), hb ? 32'(model_lock) : 32'd0);
        chk("R10 top id_valid", 32'(t_idv), 32'(ht));
        chk("R10 top id_data", 32'(t_idd), ht ? 32'(model_lock) : 32'd0);
        id_mode = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic random_reqs(int n);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            logic [1:0] k;
            int r;
            r = $urandom % 4;
            if (r == 0) a = AW'($urandom % 16384);
            else if (r == 1) a = AW'(19'h7C000 + ($urandom % 16384));
            else a = AW'($urandom);
            k = 2'(1 + ($urandom % 3));
            do_req(k, a, ($urandom % 4) == 0);
            if (($urandom % 8) == 0) do_id(($urandom % 2) ? 19'h00002 : 19'h7E002);
            @(negedge clk); op_done = 1'b1; hv_override = 1'b0;
            @(negedge clk); op_done = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset resp_valid", 32'(b_valid), 32'd0);
        chk("R9 reset ov_fault", 32'(b_fault), 32'd0);
        chk("R10 reset id_valid", 32'(b_idv), 32'd0);
        do_id(19'h00002);               // R3 lock clear after power-on
        do_id(19'h7E002);
        do_id(19'h00003);

        // R1 R2 boundaries
        do_req(2'd1, 19'h01FFF, 1'b0);
        do_req(2'd1, 19'h02000, 1'b0);
        do_req(2'd2, 19'h02FFF, 1'b0);
        do_req(2'd2, 19'h03000, 1'b0);
        do_req(2'd1, 19'h03FFF, 1'b0);
        do_req(2'd1, 19'h04000, 1'b0);
        do_req(2'd2, 19'h7BFFF, 1'b0);
        do_req(2'd2, 19'h7C000, 1'b0);
        do_req(2'd1, 19'h7D000, 1'b0);
        do_req(2'd1, 19'h7E000, 1'b0);
        do_req(2'd3, 19'h00000, 1'b0);  // R7 unlocked chip erase

        // R11 kind 0 gives no response
        @(negedge clk); req_valid = 1'b1; req_kind = 2'd0;
        @(negedge clk);
        chk("R11 no response for kind 0", 32'(b_valid), 32'd0);
        req_valid = 1'b0;

        random_reqs(150);

        // R4 arm the lock
        @(negedge clk); arm_lock = 1'b1;
        @(negedge clk); arm_lock = 1'b0; model_lock = 1'b1;
        do_id(19'h00002);
        do_id(19'h7E002);

        // R6 blocked requests; R7 chip erase keeps boot
        do_req(2'd1, 19'h00000, 1'b0);
        do_req(2'd2, 19'h01FFF, 1'b0);
        do_req(2'd2, 19'h7E000, 1'b0);
        do_req(2'd3, 19'h12345, 1'b0);
        do_req(2'd1, 19'h02000, 1'b0);
        // R8 override lets boot requests through
        do_req(2'd3, 19'h00000, 1'b1);
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;

        // R9 override dropped early gives a single fault pulse
        do_req(2'd1, 19'h00010, 1'b1);
        hv_override = 1'b0;
        @(negedge clk);
        chk("R9 fault on early drop", 32'(b_fault), 32'd1);
        @(negedge clk);
        chk("R9 fault is one pulse", 32'(b_fault), 32'd0);

        // R9 override held until op_done gives no fault
        do_req(2'd2, 19'h00010, 1'b1);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0; hv_override = 1'b0;
        chk("R9 no fault when held", 32'(b_fault), 32'd0);
        @(negedge clk);
        chk("R9 no fault after done", 32'(b_fault), 32'd0);

        random_reqs(150);

        // R3 normal reset keeps the lock
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        do_id(19'h00002);
        do_req(2'd1, 19'h00100, 1'b0);

        // R3 power-on reset clears it
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        idle(2);
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1; model_lock = 1'b0;
        do_id(19'h00002);
        do_req(2'd1, 19'h00100, 1'b0);

        // R4 arm ignored under normal reset
        @(negedge clk); rst_n = 1'b0; arm_lock = 1'b1;
        @(negedge clk); arm_lock = 1'b0; rst_n = 1'b1;
        do_id(19'h00002);

        idle(2);
        finish_run();
    end
endmodule